// File: doc/BRIEF.md
# Tile Map Band Prefetcher

This block feeds a tile-based 640x480 display. The screen is an 80x60 grid of 8x8 tiles. Each band is one tile row, eight scanlines tall. When a band starts, the prefetcher loads the tile row that is shown next from external memory into an on-chip line buffer. It does this in two passes. First it reads the 80 two-byte map entries of the requested tile row and keeps their tile numbers and flip bits. Then it walks those 80 entries in column order and copies each tile's 24-byte bitmap into the buffer, three bytes for each pixel row.

The line buffer has two banks. The bank being filled is never the bank being displayed. A band-start pulse swaps the two banks and starts the next fetch into the bank that has just been released. The pixel serialiser reads the displayed bank by tile column and pixel row. It gets back one 24-bit pixel row of that tile together with the tile's horizontal and vertical flip bits. External memory is reached through one arbitrated byte-wide read port with a request/valid handshake.

Top module: `tileBandPrefetcher`

## Requirements
- R1: After reset, `memReq` and `fillDone` are low, and `memReq` stays low until the first `bandTick`.
- R2: In the cycle after a `bandTick`, the fetch begins with 160 map reads at byte address 160*fetchRow + 2*col + b, for col 0..79 and b 0..1 in ascending order. The map starts at address 0. Each entry is little-endian: the low byte is at the even address.
- R3: After the map reads come 80×24 bitmap reads, tile column by tile column. Tile column c reads addresses 9600 + 24*t + k, for k 0..23, where t is bits [9:0] of entry c. Bits [13:10] of the entry are ignored. Every address is taken modulo 2^15.
- R4: After the next `bandTick`, for tile column c and pixel row r, `rdWord` returns {byte 3r+2, byte 3r+1, byte 3r} of that tile's bitmap. Bits [7:0] hold byte 3r. The value appears one clock after `rdTile`/`rdRow` are applied.
- R5: `rdFlipH` returns entry bit 14 and `rdFlipV` returns entry bit 15 of the addressed column. Both have the same one-clock latency as `rdWord`.
- R6: While `memReq` is high and `memValid` is low, and no `bandTick` arrives, `memReq` stays high in the next cycle with `memAddr` unchanged. Each cycle with both `memReq` and `memValid` high consumes exactly one byte.
- R7: `fillDone` rises in the cycle after the last bitmap byte is accepted. It then stays high, with `memReq` low, until the next `bandTick`, which clears it.
- R8: While a fill is in progress, reads return the previously fetched band unchanged.
- R9: A `bandTick` during a fill abandons that fill. The bytes offered in that cycle are ignored, and a complete fresh fetch starts at the first map read of the new row.
- R10: A complete fetch performs exactly 2080 accepted reads: 160 map reads and 1920 bitmap reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bandTick | input | 1 | Band boundary pulse: swaps the banks and starts a fetch |
| fetchRow | input | 6 | Tile row to fetch, sampled with `bandTick` |
| memReq | output | 1 | Read request to the memory arbiter |
| memAddr | output | 15 | Byte address of the request |
| memValid | input | 1 | Read data valid for the current request |
| memData | input | 8 | Read data byte |
| fillDone | output | 1 | The fetch into the hidden bank is complete |
| rdTile | input | 7 | Tile column to read from the displayed bank |
| rdRow | input | 3 | Pixel row within the tile |
| rdWord | output | 24 | Eight 3-bit pixels of the addressed tile row |
| rdFlipH | output | 1 | Horizontal flip bit of the addressed tile |
| rdFlipV | output | 1 | Vertical flip bit of the addressed tile |

## Verification
The fetch is exercised on the first tile row, the last tile row and middle rows. Each run uses memory response latencies of 0, 1 and 2 extra cycles. This separates the address order from any dependence on handshake timing. Map entries carry varying values in the ignored bits, every flip combination, and tile numbers above 965, whose bitmap addresses wrap past 2^15. These catch decoding errors and missing wrap-around. Every readback is made while the other bank is being filled with a different row, so a write to the wrong bank shows up. A fill abandoned partway through its bitmap pass then shows whether the restart begins cleanly at the map.

// File: rtl/tbpPkg.sv
package tbpPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MAP,
    ST_TILE,
    ST_DONE
  } fetchState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;     // band boundary: latch row
    logic capture;   // memory byte accepted this cycle
    logic mapPhase;  // byte belongs to the map pass
  } fetchStb_t;

endpackage

// File: rtl/tbpCtrl.sv
module tbpCtrl
  import tbpPkg::*;
#(
  parameter int TILES_X = 80,
  parameter int TILE_H  = 8,
  parameter int LANES   = 3,
  parameter int COL_W   = 7,
  parameter int TROW_W  = 3,
  parameter int LANE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bandTick,
  input  logic              memValid,
  output logic              memReq,
  output logic              fillDone,
  output fetchStb_t         stb,
  output logic [COL_W-1:0]  entry,
  output logic [TROW_W-1:0] tRow,
  output logic [LANE_W-1:0] lane,
  output logic              half,
  output logic              dispBank
);

  fetchState_t state;

  logic lastEntry, lastRow, lastLane, capture;

  assign lastEntry = (entry == COL_W'(TILES_X - 1));
  assign lastRow   = (tRow == TROW_W'(TILE_H - 1));
  assign lastLane  = (lane == LANE_W'(LANES - 1));

  assign memReq   = (state == ST_MAP) || (state == ST_TILE);
  assign fillDone = (state == ST_DONE);
  assign capture  = memValid && memReq && !bandTick;

  always_comb begin
    stb.start    = bandTick;
    stb.capture  = capture;
    stb.mapPhase = (state == ST_MAP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      entry    <= '0;
      tRow     <= '0;
      lane     <= '0;
      half     <= 1'b0;
      dispBank <= 1'b0;
    end else if (bandTick) begin
      state    <= ST_MAP;
      entry    <= '0;
      tRow     <= '0;
      lane     <= '0;
      half     <= 1'b0;
      dispBank <= ~dispBank;
    end else if (capture) begin
      if (state == ST_MAP) begin
        if (half) begin
          half <= 1'b0;
          if (lastEntry) begin
            entry <= '0;
            state <= ST_TILE;
          end else begin
            entry <= entry + 1'b1;
          end
        end else begin
          half <= 1'b1;
        end
      end else begin
        if (lastLane) begin
          lane <= '0;
          if (lastRow) begin
            tRow <= '0;
            if (lastEntry) begin
              entry <= '0;
              state <= ST_DONE;
            end else begin
              entry <= entry + 1'b1;
            end
          end else begin
            tRow <= tRow + 1'b1;
          end
        end else begin
          lane <= lane + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tbpDatapath.sv
module tbpDatapath
  import tbpPkg::*;
#(
  parameter int TILES_X     = 80,
  parameter int TILE_H      = 8,
  parameter int LANES       = 3,
  parameter int TILE_NUM_W  = 10,
  parameter int ADDR_W      = 15,
  parameter int MAP_BASE    = 0,
  parameter int BITMAP_BASE = 9600,
  parameter int ROW_W       = 6,
  parameter int COL_W       = 7,
  parameter int TROW_W      = 3,
  parameter int LANE_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  fetchStb_t             stb,
  input  logic [ROW_W-1:0]      fetchRow,
  input  logic [COL_W-1:0]      entry,
  input  logic [TROW_W-1:0]     tRow,
  input  logic [LANE_W-1:0]     lane,
  input  logic                  half,
  input  logic                  dispBank,
  input  logic [7:0]            memData,
  output logic [ADDR_W-1:0]     memAddr,
  input  logic [COL_W-1:0]      rdTile,
  input  logic [TROW_W-1:0]     rdRow,
  output logic [LANES*8-1:0]    rdWord,
  output logic                  rdFlipH,
  output logic                  rdFlipV
);

  localparam int WORD_W     = LANES * 8;
  localparam int TILE_BYTES = LANES * TILE_H;
  localparam int MAP_ROW_B  = TILES_X * 2;
  localparam int LINE_WORDS = TILES_X * TILE_H;
  localparam int LINE_W     = $clog2(LINE_WORDS);
  localparam int IDX_W      = TILE_NUM_W + 2;

  logic [ROW_W-1:0]  rowQ;
  logic [7:0]        lowByte;
  logic [7:0]        laneBuf [LANES-1];
  logic [IDX_W-1:0]  idxMem  [TILES_X];
  logic [IDX_W-1:0]  curIdx;
  logic [WORD_W-1:0] wrWord;
  logic [LINE_W-1:0] wrIdx, rdIdx;
  logic [ADDR_W-1:0] mapAddr, tileAddr;
  logic              fillBank;

  assign fillBank = ~dispBank;
  assign curIdx   = idxMem[entry];

  // Address generation, naturally modulo 2^ADDR_W
  assign mapAddr  = ADDR_W'(MAP_BASE) + ADDR_W'(rowQ) * ADDR_W'(MAP_ROW_B)
                  + ADDR_W'(entry) * ADDR_W'(2) + ADDR_W'(half);
  assign tileAddr = ADDR_W'(BITMAP_BASE)
                  + ADDR_W'(curIdx[TILE_NUM_W-1:0]) * ADDR_W'(TILE_BYTES)
                  + ADDR_W'(tRow) * ADDR_W'(LANES) + ADDR_W'(lane);
  assign memAddr  = stb.mapPhase ? mapAddr : tileAddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rowQ    <= '0;
      lowByte <= '0;
    end else begin
      if (stb.start) rowQ <= fetchRow;
      if (stb.capture && stb.mapPhase && !half) lowByte <= memData;
    end
  end

  // Map entries: keep flipV, flipH and tile number; bits 13:10 dropped
  always_ff @(posedge clk) begin
    if (stb.capture && stb.mapPhase && half)
      idxMem[entry] <= {memData[7:6], memData[TILE_NUM_W-9:0], lowByte};
  end

  // Byte collection for one pixel row
  always_ff @(posedge clk) begin
    if (stb.capture && !stb.mapPhase && (lane != LANE_W'(LANES - 1)))
      laneBuf[lane] <= memData;
  end

  always_comb begin
    wrWord = '0;
    for (int k = 0; k < LANES - 1; k++) wrWord[8*k +: 8] = laneBuf[k];
    wrWord[WORD_W-1 -: 8] = memData;
  end

  assign wrIdx = LINE_W'(entry) * LINE_W'(TILE_H) + LINE_W'(tRow);
  assign rdIdx = LINE_W'(rdTile) * LINE_W'(TILE_H) + LINE_W'(rdRow);

  logic [WORD_W-1:0] bankWord [2];
  logic [1:0]        bankFlip [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WORD_W-1:0] pix  [LINE_WORDS];
    logic [1:0]        flip [TILES_X];
    logic              wrEn;

    assign wrEn = stb.capture && !stb.mapPhase && (fillBank == 1'(b));

    always_ff @(posedge clk) begin
      if (wrEn) begin
        if (lane == LANE_W'(LANES - 1)) pix[wrIdx] <= wrWord;
        if ((tRow == '0) && (lane == '0)) flip[entry] <= curIdx[IDX_W-1 -: 2];
      end
    end

    assign bankWord[b] = pix[rdIdx];
    assign bankFlip[b] = flip[rdTile];
  end

  always_ff @(posedge clk) begin
    rdWord  <= bankWord[dispBank];
    rdFlipH <= bankFlip[dispBank][0];
    rdFlipV <= bankFlip[dispBank][1];
  end

endmodule

// File: rtl/tileBandPrefetcher.sv
module tileBandPrefetcher
  import tbpPkg::*;
#(
  parameter int TILES_X     = 80,
  parameter int TILES_Y     = 60,
  parameter int TILE_H      = 8,
  parameter int LANES       = 3,
  parameter int TILE_NUM_W  = 10,
  parameter int ADDR_W      = 15,
  parameter int MAP_BASE    = 0,
  parameter int BITMAP_BASE = 9600,
  parameter int ROW_W       = $clog2(TILES_Y),
  parameter int COL_W       = $clog2(TILES_X),
  parameter int TROW_W      = $clog2(TILE_H)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bandTick,
  input  logic [ROW_W-1:0]   fetchRow,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic               memValid,
  input  logic [7:0]         memData,
  output logic               fillDone,
  input  logic [COL_W-1:0]   rdTile,
  input  logic [TROW_W-1:0]  rdRow,
  output logic [LANES*8-1:0] rdWord,
  output logic               rdFlipH,
  output logic               rdFlipV
);

  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  fetchStb_t         stb;
  logic [COL_W-1:0]  entry;
  logic [TROW_W-1:0] tRow;
  logic [LANE_W-1:0] lane;
  logic              half;
  logic              dispBank;

  tbpCtrl #(
    .TILES_X(TILES_X), .TILE_H(TILE_H), .LANES(LANES),
    .COL_W(COL_W), .TROW_W(TROW_W), .LANE_W(LANE_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .bandTick(bandTick), .memValid(memValid),
    .memReq(memReq), .fillDone(fillDone), .stb(stb), .entry(entry),
    .tRow(tRow), .lane(lane), .half(half), .dispBank(dispBank)
  );

  tbpDatapath #(
    .TILES_X(TILES_X), .TILE_H(TILE_H), .LANES(LANES),
    .TILE_NUM_W(TILE_NUM_W), .ADDR_W(ADDR_W), .MAP_BASE(MAP_BASE),
    .BITMAP_BASE(BITMAP_BASE), .ROW_W(ROW_W), .COL_W(COL_W),
    .TROW_W(TROW_W), .LANE_W(LANE_W)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .fetchRow(fetchRow),
    .entry(entry), .tRow(tRow), .lane(lane), .half(half),
    .dispBank(dispBank), .memData(memData), .memAddr(memAddr),
    .rdTile(rdTile), .rdRow(rdRow), .rdWord(rdWord),
    .rdFlipH(rdFlipH), .rdFlipV(rdFlipV)
  );

endmodule

// File: rtl/tbpChecker.sv
module tbpChecker #(
  parameter int TILES_X  = 80,
  parameter int ADDR_W   = 15,
  parameter int MAP_BASE = 0,
  parameter int ROW_W    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bandTick,
  input logic [ROW_W-1:0]  fetchRow,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memValid,
  input logic              fillDone
);

  function automatic logic [ADDR_W-1:0] rowStart(input logic [ROW_W-1:0] r);
    return ADDR_W'(MAP_BASE) + ADDR_W'(r) * ADDR_W'(TILES_X * 2);
  endfunction

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memValid && !bandTick) |=> (memReq && $stable(memAddr))); // R6

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fillDone |-> !memReq); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fillDone && !bandTick) |=> fillDone); // R7

  AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fillDone) |-> $past(memReq && memValid && !bandTick)); // R7

  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    bandTick |=> (memReq && !fillDone && memAddr == rowStart($past(fetchRow)))); // R9

endmodule

bind tileBandPrefetcher tbpChecker #(
  .TILES_X(TILES_X), .ADDR_W(ADDR_W), .MAP_BASE(MAP_BASE), .ROW_W(ROW_W)
) i_tbpChecker (
  .clk(clk), .rst_n(rst_n), .bandTick(bandTick), .fetchRow(fetchRow),
  .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .fillDone(fillDone)
);

// File: tb/test_tileBandPrefetcher.sv
module test_tileBandPrefetcher;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bandTick;
  logic [5:0]  fetchRow;
  logic        memReq;
  logic [14:0] memAddr;
  logic        memValid;
  logic [7:0]  memData;
  logic        fillDone;
  logic [6:0]  rdTile;
  logic [2:0]  rdRow;
  logic [23:0] rdWord;
  logic        rdFlipH, rdFlipV;

  always #5 clk = ~clk;

  tileBandPrefetcher i_tileBandPrefetcher (
    .clk(clk), .rst_n(rst_n), .bandTick(bandTick), .fetchRow(fetchRow),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .fillDone(fillDone), .rdTile(rdTile), .rdRow(rdRow), .rdWord(rdWord),
    .rdFlipH(rdFlipH), .rdFlipV(rdFlipV)
  );

  typedef struct packed {
    logic [5:0] row;
    logic [3:0] pat;
    logic [1:0] lat;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{6'd0,  4'd3,  2'd0},
    '{6'd59, 4'd10, 2'd1},
    '{6'd17, 4'd15, 2'd2},
    '{6'd33, 4'd6,  2'd1}
  };

  int   checks = 0, fails = 0;
  bit   finished = 0;
  logic [7:0] mem [32768];

  int   lat = 0, cnt = 0;
  bit   tracking = 0;
  int   nReads = 0, mapErrs = 0, tileErrs = 0;
  int   trackRow = 0, trackPat = 0;
  logic [14:0] badGot, badExp;

  function automatic logic [15:0] entryOf(input int row, input int col, input int pat);
    int t;
    t = (col * 37 + row * 11 + pat * 97) % 1024;
    return {1'(col >> 1), 1'(col), 4'(pat), 10'(t)};
  endfunction

  function automatic logic [14:0] expAddr(input int row, input int pat, input int n);
    logic [15:0] e;
    int m;
    if (n < 160) return 15'(160 * row + n);
    m = n - 160;
    e = entryOf(row, m / 24, pat);
    return 15'(9600 + 24 * int'(e[9:0]) + (m % 24));
  endfunction

  function automatic logic [23:0] expWord(input int row, input int pat, input int col, input int r);
    logic [15:0] e;
    int a;
    e = entryOf(row, col, pat);
    a = 9600 + 24 * int'(e[9:0]) + 3 * r;
    return {mem[(a + 2) % 32768], mem[(a + 1) % 32768], mem[a % 32768]};
  endfunction

  // Memory model: answers after lat idle cycles, one byte per request
  always @(negedge clk) begin
    if (!rst_n || !memReq) begin
      memValid = 1'b0;
      cnt = 0;
    end else if (memValid) begin
      memValid = 1'b0;
      cnt = 0;
    end else if (cnt >= lat) begin
      memValid = 1'b1;
      memData  = mem[memAddr];
      if (tracking) begin
        if (memAddr !== expAddr(trackRow, trackPat, nReads)) begin
          if (nReads < 160) mapErrs++; else tileErrs++;
          if (mapErrs + tileErrs == 1) begin
            badGot = memAddr;
            badExp = expAddr(trackRow, trackPat, nReads);
          end
        end
        nReads++;
      end
    end else begin
      cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic writeMapRow(input int row, input int pat);
    for (int c = 0; c < 80; c++) begin
      logic [15:0] e;
      e = entryOf(row, c, pat);
      mem[160 * row + 2 * c]     = e[7:0];
      mem[160 * row + 2 * c + 1] = e[15:8];
    end
  endtask

  task automatic tick(input int row, input int pat);
    @(negedge clk);
    bandTick = 1'b1;
    fetchRow = 6'(row);
    @(posedge clk);
    #1;
    bandTick = 1'b0;
    tracking = 1'b1;
    nReads = 0; mapErrs = 0; tileErrs = 0;
    trackRow = row; trackPat = pat;
  endtask

  task automatic waitDone();
    int waited;
    waited = 0;
    while (!fillDone && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    tracking = 1'b0;
    chk(fillDone, "R7", "fillDone raised", 32'(fillDone), 32'd1);
    chk(!memReq, "R7", "memReq low when done", 32'(memReq), 32'd0);
    chk(mapErrs == 0, "R2", "map address order", 32'(badGot), 32'(badExp));
    chk(tileErrs == 0, "R3", "bitmap address order", 32'(badGot), 32'(badExp));
    chk(nReads == 2080, "R10", "accepted read count", 32'(nReads), 32'd2080);
  endtask

  task automatic verifyBank(input int row, input int pat);
    for (int c = 0; c < 80; c++) begin
      for (int r = 0; r < 8; r++) begin
        logic [15:0] e;
        @(negedge clk);
        rdTile = 7'(c);
        rdRow  = 3'(r);
        @(negedge clk);
        chk(rdWord === expWord(row, pat, c, r), "R4", "pixel row word",
            32'(rdWord), 32'(expWord(row, pat, c, r)));
        if (r == 0) begin
          e = entryOf(row, c, pat);
          chk({rdFlipV, rdFlipH} === e[15:14], "R5", "flip bits",
              32'({rdFlipV, rdFlipH}), 32'(e[15:14]));
        end
      end
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; bandTick = 1'b0; fetchRow = '0;
    rdTile = '0; rdRow = '0; memValid = 1'b0; memData = '0;
    for (int a = 0; a < 32768; a++) mem[a] = 8'(a * 5 + (a >> 7));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!memReq && !fillDone, "R1", "outputs in reset", 32'({memReq, fillDone}), 32'd0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(!memReq, "R1", "no request before first band", 32'(memReq), 32'd0);
    chk(!fillDone, "R1", "no done before first band", 32'(fillDone), 32'd0);

    // Vector table: fetch a row, then read it back while the next row fills (R8)
    foreach (VEC[v]) begin
      int r, r2, p;
      r  = int'(VEC[v].row);
      r2 = (r + 1) % 60;
      p  = int'(VEC[v].pat);
      lat = int'(VEC[v].lat);
      writeMapRow(r, p);
      writeMapRow(r2, p);
      tick(r, p);
      waitDone();
      tick(r2, p);
      verifyBank(r, p);
      chk(!fillDone, "R8", "readback overlapped the fill", 32'(fillDone), 32'd0);
    end

    // R9: abandon a fill during its bitmap pass and restart on another row
    lat = 0;
    writeMapRow(5, 9);
    writeMapRow(6, 9);
    tick(5, 9);
    repeat (400) @(negedge clk);
    chk(!fillDone && memReq, "R9", "fill still running before abort",
        32'({fillDone, memReq}), 32'd1);
    tick(6, 9);
    waitDone();
    tick(7, 2);
    verifyBank(6, 9);
    chk(!fillDone, "R8", "readback overlapped the fill", 32'(fillDone), 32'd0);

    summary();
  end

endmodule